// File: doc/BRIEF.md
# Activation Matrix Round Sequencer

The sequencer walks a round counter across a grid of rows and columns, at most 48 by 48, so one pass covers up to 2304 rounds. Each driver owns a bitmap of 144 sixteen-bit words. Every round of the grid maps to one bit of that bitmap. When the bit for the current round is set, the driver's enable output is high for that round. The enables go to a pulse timer. The timer returns an end-of-period strobe, and each strobe moves the grid on by one round.

Software fills the bitmaps through a plain write port, which takes a driver index, a word address and a data word. The number of rows, the number of columns and the total round count are sampled when a run starts. A smaller grid shortens the pass; a 4 by 4 grid, for example, gives 16 rounds. When the number of completed rounds reaches the programmed total, the run ends, the done flag rises and every enable drops. This state holds until a new run is started.

Top module: `act_round_seq`

## Requirements
- R1: After reset the block is idle: all enables are low, the done flag is low, and the row and column indices are 0.
- R2: A `run_start` pulse sets the row index, the column index and the completed-round count to 0 and clears done. On the same edge it samples `row_span`, `col_span` and `round_total`, and from then on the block is running. This also applies when a run is already in progress.
- R3: The round index is row × 48 + column. Its bitmap word is the index divided by 16, and its bit is 15 minus (index mod 16), so bit 15 holds the lowest column of the word. While running, `drv_en[d]` equals that bit of driver d's bitmap for the current row and column.
- R4: While running, the row and column advance only on a cycle where `period_end` is high. They hold on every other cycle.
- R5: Each strobe moves the column up by 1. When the column reaches the column span, it returns to 0 and the row moves up by 1. When the row reaches the row span, it returns to 0.
- R6: A span value of 0, or any value above 48, counts as a span of 48.
- R7: With a nonzero total, the strobe that brings the completed-round count to the total raises `seq_done`. From then on the indices are frozen and all enables are low until the next `run_start`. A total of 0 runs without end, and the grid keeps wrapping.
- R8: A write changes nothing when its address is 144 or above, or when its driver index is not below the driver count.
- R9: An accepted write changes only the addressed word of the addressed driver's bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_start | input | 1 | Starts a run; samples the spans and the total |
| row_span | input | 6 | Number of rows in the grid (0 or >48 means 48) |
| col_span | input | 6 | Number of columns in the grid (0 or >48 means 48) |
| round_total | input | 12 | Number of rounds before the run ends (0 means no end) |
| period_end | input | 1 | End-of-period strobe from the pulse timer |
| wr_en | input | 1 | Bitmap write strobe |
| wr_drv | input | DRV_W (2) | Driver index of the write |
| wr_addr | input | 10 | Word address of the write |
| wr_data | input | 16 | Word to write |
| drv_en | output | NUM_DRV (3) | Per-driver enable for the current round |
| row_idx | output | 6 | Current row |
| col_idx | output | 6 | Current column |
| seq_done | output | 1 | The run has reached its round total |

## Verification
Three corner cases get the most attention. The first is the wrap of the column into the next row. If that step is wrong, the grid skips a row or stretches a row past its span, and every enable after that point is wrong. The second is bit order inside a word. Directed rows and a column-0 bitmap make a reversed lane order or a wrong divide by 16 light the wrong round. The third is the final strobe of a run. An off-by-one there ends the run a round early or a round late. A done flag that fails to stick, or that is cleared by a stray strobe, shows up as enables that come back on. Two further cases are covered. Spans above 48 and a total of 0 exercise the clamping and the unbounded run. Writes to an out-of-range driver, and to addresses that alias a real word through a truncated address, are followed by a full grid pass. That pass catches any bitmap word that was changed.

// File: rtl/actseq_pkg.sv
package actseq_pkg;
  localparam int GRID_DIM = 48;
  localparam int DIM_W    = 6;
  localparam int ROUND_W  = 12;
  localparam int WORD_W   = 16;
  localparam int WORD_CNT = (GRID_DIM * GRID_DIM) / WORD_W;
  localparam int WIDX_W   = 8;
  localparam int LANE_W   = 4;
  localparam int ADDR_W   = 10;

  typedef struct packed {
    logic [DIM_W-1:0]   rows;
    logic [DIM_W-1:0]   cols;
    logic [ROUND_W-1:0] total;
  } span_cfg_t;

  // a span of 0 or anything past the full grid means the full grid
  function automatic logic [DIM_W-1:0] clamp_span(input logic [DIM_W-1:0] v);
    if (v == '0 || v > DIM_W'(GRID_DIM)) return DIM_W'(GRID_DIM);
    return v;
  endfunction

  function automatic logic [ROUND_W-1:0] round_of(input logic [DIM_W-1:0] row,
                                                  input logic [DIM_W-1:0] col);
    return ROUND_W'(row) * ROUND_W'(GRID_DIM) + ROUND_W'(col);
  endfunction

  function automatic logic [WIDX_W-1:0] word_of(input logic [ROUND_W-1:0] r);
    return r[ROUND_W-1:LANE_W];
  endfunction

  // lowest column of a word sits in its top bit
  function automatic logic [LANE_W-1:0] lane_of(input logic [ROUND_W-1:0] r);
    return LANE_W'(WORD_W - 1) - r[LANE_W-1:0];
  endfunction
endpackage

// File: rtl/round_ctr.sv
module round_ctr
  import actseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_start,
  input  logic             period_end,
  input  span_cfg_t        cfg_in,
  output logic [DIM_W-1:0] row_q,
  output logic [DIM_W-1:0] col_q,
  output logic             active_q,
  output logic             done_q
);
  span_cfg_t          cfg_q;
  logic [ROUND_W-1:0] cnt_q;
  logic [ROUND_W-1:0] cnt_nxt;
  logic               step;
  logic               col_last;
  logic               row_last;
  logic               final_step;

  assign step       = active_q && period_end;
  assign cnt_nxt    = cnt_q + ROUND_W'(1);
  assign col_last   = (col_q == cfg_q.cols - DIM_W'(1));
  assign row_last   = (row_q == cfg_q.rows - DIM_W'(1));
  assign final_step = step && (cfg_q.total != '0) && (cnt_nxt == cfg_q.total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      cnt_q    <= '0;
      row_q    <= '0;
      col_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (run_start) begin
      cfg_q.rows  <= clamp_span(cfg_in.rows);
      cfg_q.cols  <= clamp_span(cfg_in.cols);
      cfg_q.total <= cfg_in.total;
      cnt_q       <= '0;
      row_q       <= '0;
      col_q       <= '0;
      active_q    <= 1'b1;
      done_q      <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_nxt;
      if (col_last) begin
        col_q <= '0;
        row_q <= row_last ? '0 : row_q + DIM_W'(1);
      end else begin
        col_q <= col_q + DIM_W'(1);
      end
      if (final_step) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  assert_col_in_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> col_q < cfg_q.cols);
  assert_row_in_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> row_q < cfg_q.rows);
  assert_hold_without_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !run_start) |=> ($stable(row_q) && $stable(col_q)));
  assert_done_sticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !run_start) |=> done_q);
  assert_done_at_total_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cnt_q == cfg_q.total && cfg_q.total != '0));
  assert_done_stops_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && active_q));
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (row_q == '0 && col_q == '0 && active_q && !done_q));
endmodule

// File: rtl/act_bitmap.sv
module act_bitmap
  import actseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [WIDX_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WIDX_W-1:0] rd_word,
  input  logic [LANE_W-1:0] rd_lane,
  output logic              rd_bit
);
  logic [WORD_W-1:0] words [WORD_CNT];
  logic [WORD_W-1:0] rd_data;

  always_ff @(posedge clk) begin
    if (wr_hit) words[wr_word] <= wr_data;
  end

  assign rd_data = words[rd_word];
  assign rd_bit  = rd_data[rd_lane];

  assert_unwritten_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> (($stable(rd_word) && $stable(rd_lane)) |-> $stable(rd_bit)));
endmodule

// File: rtl/act_round_seq.sv
module act_round_seq
  import actseq_pkg::*;
#(
  parameter int NUM_DRV = 3,
  parameter int DRV_W   = (NUM_DRV > 1) ? $clog2(NUM_DRV) + ((NUM_DRV & (NUM_DRV - 1)) == 0 ? 0 : 0) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_start,
  input  logic [5:0]         row_span,
  input  logic [5:0]         col_span,
  input  logic [11:0]        round_total,
  input  logic               period_end,
  input  logic               wr_en,
  input  logic [DRV_W-1:0]   wr_drv,
  input  logic [9:0]         wr_addr,
  input  logic [15:0]        wr_data,
  output logic [NUM_DRV-1:0] drv_en,
  output logic [5:0]         row_idx,
  output logic [5:0]         col_idx,
  output logic               seq_done
);
  span_cfg_t          cfg_in;
  logic [DIM_W-1:0]   row_q;
  logic [DIM_W-1:0]   col_q;
  logic               active;
  logic               done;
  logic [ROUND_W-1:0] round_now;
  logic [WIDX_W-1:0]  rd_word;
  logic [LANE_W-1:0]  rd_lane;
  logic               addr_ok;
  logic [NUM_DRV-1:0] wr_hit;
  logic [NUM_DRV-1:0] bit_now;

  assign cfg_in = '{rows: row_span, cols: col_span, total: round_total};

  round_ctr u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_start (run_start),
    .period_end(period_end),
    .cfg_in    (cfg_in),
    .row_q     (row_q),
    .col_q     (col_q),
    .active_q  (active),
    .done_q    (done)
  );

  assign round_now = round_of(row_q, col_q);
  assign rd_word   = word_of(round_now);
  assign rd_lane   = lane_of(round_now);
  assign addr_ok   = wr_addr < ADDR_W'(WORD_CNT);

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    assign wr_hit[d] = wr_en && addr_ok && (wr_drv == DRV_W'(d));

    act_bitmap u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit[d]),
      .wr_word(wr_addr[WIDX_W-1:0]),
      .wr_data(wr_data),
      .rd_word(rd_word),
      .rd_lane(rd_lane),
      .rd_bit (bit_now[d])
    );

    assign drv_en[d] = active && bit_now[d];
  end

  assign row_idx  = row_q;
  assign col_idx  = col_q;
  assign seq_done = done;

  assert_word_in_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word < WIDX_W'(WORD_CNT));
  assert_one_map_written_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));
  assert_quiet_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> drv_en == '0);
  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> drv_en == '0);
endmodule

// File: tb/act_round_seq_test.sv
`timescale 1ns/1ps
module act_round_seq_test;
  localparam int ND = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_start = 1'b0;
  logic [5:0]  row_span = '0;
  logic [5:0]  col_span = '0;
  logic [11:0] round_total = '0;
  logic        period_end = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_drv = '0;
  logic [9:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [ND-1:0] drv_en;
  logic [5:0]  row_idx;
  logic [5:0]  col_idx;
  logic        seq_done;

  act_round_seq #(.NUM_DRV(ND), .DRV_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .row_span(row_span),
    .col_span(col_span), .round_total(round_total), .period_end(period_end),
    .wr_en(wr_en), .wr_drv(wr_drv), .wr_addr(wr_addr), .wr_data(wr_data),
    .drv_en(drv_en), .row_idx(row_idx), .col_idx(col_idx), .seq_done(seq_done)
  );

  always #2.5 clk = ~clk;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  logic [15:0] mdl [ND][144];
  int m_row, m_col, m_cnt, m_rows, m_cols, m_total;
  bit m_active, m_done;

  function automatic int span_of(input int v);
    return (v == 0 || v > 48) ? 48 : v;
  endfunction

  function automatic logic [ND-1:0] exp_en();
    logic [ND-1:0] e;
    int idx;
    idx = m_row * 48 + m_col;
    for (int d = 0; d < ND; d++)
      e[d] = m_active ? mdl[d][idx / 16][15 - (idx % 16)] : 1'b0;
    return e;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d (row %0d col %0d)", req, act, exp, m_row, m_col);
    end
  endtask

  task automatic check_state(input string req);
    chk(req, int'(row_idx), m_row);
    chk(req, int'(col_idx), m_col);
    chk(req, int'(seq_done), int'(m_done));
    chk(req, int'(drv_en), int'(exp_en()));
  endtask

  task automatic wr(input int d, input int addr, input logic [15:0] data);
    wr_en = 1'b1; wr_drv = 2'(d); wr_addr = 10'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (addr < 144 && d < ND) mdl[d][addr] = data;
  endtask

  task automatic start(input int rows, input int cols, input int total);
    row_span = 6'(rows); col_span = 6'(cols); round_total = 12'(total);
    run_start = 1'b1;
    @(negedge clk);
    run_start = 1'b0;
    m_rows = span_of(rows); m_cols = span_of(cols); m_total = total;
    m_row = 0; m_col = 0; m_cnt = 0; m_active = 1; m_done = 0;
    check_state("R2");
  endtask

  task automatic strobe(input string req);
    period_end = 1'b1;
    @(negedge clk);
    period_end = 1'b0;
    if (m_active) begin
      m_cnt++;
      m_col++;
      if (m_col == m_cols) begin
        m_col = 0;
        m_row++;
        if (m_row == m_rows) m_row = 0;
      end
      if (m_total != 0 && m_cnt == m_total) begin
        m_done = 1; m_active = 0;
      end
    end
    check_state(req);
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    check_state(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int on0, on1;
    void'($urandom(32'h5eed_1234));
    m_row = 0; m_col = 0; m_cnt = 0; m_rows = 48; m_cols = 48; m_total = 0;
    m_active = 0; m_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state (bitmap is still unwritten, so no enable check against it)
    chk("R1", int'(drv_en), 0);
    chk("R1", int'(seq_done), 0);
    chk("R1", int'(row_idx), 0);
    chk("R1", int'(col_idx), 0);

    for (int d = 0; d < ND; d++)
      for (int a = 0; a < 144; a++) wr(d, a, 16'($urandom));
    check_state("R1");
    strobe("R1");  // strobe while idle does nothing

    // R5 R7: 4x4 grid, 16 rounds, then frozen
    start(4, 4, 16);
    for (int i = 0; i < 16; i++) strobe("R5");
    chk("R7", int'(seq_done), 1);
    for (int i = 0; i < 5; i++) strobe("R7");
    idle("R7");

    // R3: first-row pattern on driver 0, column-0 pattern on driver 1
    for (int a = 0; a < 144; a++) begin
      wr(0, a, (a < 3) ? 16'hFFFF : 16'h0000);
      wr(1, a, (a % 3 == 0) ? 16'h8000 : 16'h0000);
    end
    start(0, 63, 2304);  // R6: both spans clamp to 48
    on0 = 0; on1 = 0;
    for (int i = 0; i < 2304; i++) begin
      on0 += int'(drv_en[0]);
      on1 += int'(drv_en[1]);
      strobe("R3");
    end
    chk("R3", on0, 48);
    chk("R3", on1, 48);
    chk("R6", int'(seq_done), 1);

    // R8 R9: ignored writes, including one that aliases word 16 under truncation
    for (int d = 0; d < ND; d++)
      for (int a = 0; a < 144; a++) wr(d, a, 16'($urandom));
    wr(0, 272, 16'h5A5A);
    wr(1, 144, 16'hFFFF);
    wr(2, 1023, 16'hFFFF);
    wr(3, 7, 16'hFFFF);
    wr(2, 40, 16'h0F0F);  // accepted: only driver 2 word 40 changes
    start(48, 48, 0);
    for (int i = 0; i < 2304; i++) strobe("R8");

    // R7: total of 0 runs on and wraps
    start(4, 4, 0);
    for (int i = 0; i < 40; i++) strobe("R7");
    chk("R7", int'(seq_done), 0);

    // R2: restart mid-run
    start(5, 7, 100);
    for (int i = 0; i < 9; i++) strobe("R5");
    start(3, 9, 20);

    // R4 R5 R6 R7: random spans, totals and strobe gaps
    for (int run = 0; run < 12; run++) begin
      start(int'($urandom_range(0, 10)), int'($urandom_range(0, 63)),
            int'($urandom_range(1, 300)));
      for (int i = 0; i < 360; i++) begin
        if ($urandom_range(0, 1) == 1) strobe("R5");
        else idle("R4");
      end
      if (run % 3 == 0) wr(int'($urandom_range(0, 2)), int'($urandom_range(0, 143)), 16'($urandom));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule